// File: doc/BRIEF.md
# Interrupt and Exception Sequencer

This block sits beside the main state machine of a multicycle processor control unit. It handles the extra control steps for external interrupts, internal exceptions and the return from a handler. An external request pulse is caught in a flag that stays set until the sequencer clears it. That flag is acted on only when an enable bit is set and the main sequencer reports that an instruction has finished. Exceptions for an undefined instruction or an arithmetic overflow do not depend on the enable bit. They are taken in the cycle they are reported.

When the block accepts an event, it raises `trap_go` for one cycle so that the main sequencer enters the trap path instead of fetch. The block then runs two steps of its own. In the first step it stores the already-incremented PC in the exception PC register and writes the cause code. In the second step it loads the PC with the handler vector, masks further interrupts and, for an external event only, pulses the clear for the request flag. A return instruction, once decoded, sends the block into a third step. That step reloads the PC from the exception PC register and sets the enable bit again, so handlers never nest.

The state encoding used on `ctl_state` is 0 idle, 1 save, 2 vector jump and 3 return. The cause codes are 0 for an external interrupt, 1 for an undefined instruction and 2 for overflow.

Top module: `trap_ctrl`

## Requirements
- R1: After reset `ctl_state` is 0, `irq_pend`, `int_en`, `epc_q` and `cause_q` are 0, and none of `trap_go`, `epc_we`, `cause_we`, `pc_we` or `irq_clr` is high.
- R2: A one-cycle `irq_req` makes `irq_pend` 1 from the next cycle on, and it stays 1 until a cycle in which `irq_clr` is high.
- R3: While `int_en` is 0, a pending request does not raise `trap_go` and `ctl_state` stays 0, even when `insn_end` is high.
- R4: With `int_en` 1 and a request pending, `trap_go` rises in state 0 only in a cycle where `insn_end` is 1.
- R5: In the cycle after `trap_go`, `ctl_state` is 1 and `epc_we` and `cause_we` are high, with `cause_sel` equal to the cause code. From the next cycle, `epc_q` holds the `pc_cur` value of that cycle and `cause_q` holds the code (0 external, 1 undefined instruction, 2 overflow).
- R6: State 1 is always followed by state 2. In state 2 `pc_we` is high and `pc_next` is C0000000 hex for the external and undefined-instruction causes and C0000020 hex for overflow. From the next cycle `int_en` is 0 and `ctl_state` is 0.
- R7: `irq_clr` is high only in state 2, and only for the external cause. A new `irq_req` in that same cycle wins, so `irq_pend` stays 1.
- R8: In state 0, `undef_hit` or `ovf_hit` raises `trap_go` regardless of `int_en` or `insn_end`. The priority order is undefined instruction, then overflow, then return, then external interrupt. An interrupt that loses stays pending.
- R9: `rfe_hit` in state 0, with no exception, moves to state 3 in the next cycle. In state 3 `pc_we` is high with `pc_next` equal to `epc_q`. From the cycle after state 3, `int_en` is 1 and `ctl_state` is 0.
- R10: Outside state 0, `insn_end`, `undef_hit`, `ovf_hit` and `rfe_hit` have no effect and `trap_go` stays 0. Only `irq_req` still sets the pending flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| irq_req | input | 1 | External interrupt request pulse |
| insn_end | input | 1 | Main sequencer reports the current instruction has finished |
| undef_hit | input | 1 | Decode found an undefined instruction |
| ovf_hit | input | 1 | ALU reported arithmetic overflow |
| rfe_hit | input | 1 | Decode found the return-from-handler instruction |
| pc_cur | input | DATA_W | Current, already-incremented PC |
| trap_go | output | 1 | Main sequencer must take the trap path instead of fetch |
| ctl_state | output | 2 | Step of this block: 0 idle, 1 save, 2 jump, 3 return |
| epc_we | output | 1 | Write enable of the exception PC register |
| cause_we | output | 1 | Write enable of the cause register |
| cause_sel | output | CAUSE_W | Cause code selected for writing |
| pc_we | output | 1 | PC load enable from this block |
| pc_next | output | DATA_W | Value to load into the PC when `pc_we` is high, 0 otherwise |
| irq_clr | output | 1 | Clear pulse for the request flag |
| irq_pend | output | 1 | Latched external request |
| int_en | output | 1 | Interrupt enable bit |
| epc_q | output | DATA_W | Exception PC register |
| cause_q | output | CAUSE_W | Cause register |

## Verification
Two pairs of functions can fall in the same cycle. In the first pair, the clear pulse issued in the jump step meets a fresh external request. The bench raises `irq_req` exactly in the cycle where `ctl_state` is 2 after an external trap, and it expects `irq_pend` to remain 1 afterwards. In the second pair, an exception meets an interrupt that is eligible at the same instruction end. The bench asserts `ovf_hit` or `undef_hit` together with `insn_end` while a request is pending and enabled. It then judges the stored cause, the vector and the fact that the request is still pending after the handler entry. A behavioural model running in step with the design compares every output on every cycle. Long random stretches exercise the remaining overlaps, such as a return arriving together with an exception.

// File: rtl/trap_ctrl_pkg.sv
package trap_ctrl_pkg;
  localparam int CAUSE_W = 2;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SAVE = 2'd1,
    ST_JUMP = 2'd2,
    ST_RET  = 2'd3
  } tc_state_e;

  typedef enum logic [CAUSE_W-1:0] {
    CS_EXT   = 2'd0,
    CS_UNDEF = 2'd1,
    CS_OVF   = 2'd2
  } tc_cause_e;
endpackage

// File: rtl/trap_rst_sync.sv
module trap_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ni
);
  localparam int LAST = STAGES - 1;

  logic [LAST:0] sync_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= 1'b1;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[LAST-1:0], 1'b1};
      end
    end
  endgenerate

  assign rst_ni = sync_q[LAST];
endmodule

// File: rtl/trap_req_latch.sv
module trap_req_latch (
  input  logic clk,
  input  logic rst_ni,
  input  logic req_set,
  input  logic req_clr,
  output logic pend
);
  logic pend_q;
  logic pend_d;

  // a set in the clear cycle wins so no request is lost
  always_comb begin
    pend_d = req_set | (pend_q & ~req_clr);
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) pend_q <= 1'b0;
    else         pend_q <= pend_d;
  end

  assign pend = pend_q;
endmodule

// File: rtl/trap_seq_fsm.sv
module trap_seq_fsm
  import trap_ctrl_pkg::*;
(
  input  logic               clk,
  input  logic               rst_ni,
  input  logic               insn_end,
  input  logic               undef_hit,
  input  logic               ovf_hit,
  input  logic               rfe_hit,
  input  logic               pend,
  input  logic               ie,
  output tc_state_e          state,
  output logic               trap_go,
  output logic               epc_we,
  output logic               cause_we,
  output logic [CAUSE_W-1:0] cause_sel,
  output logic               pc_we,
  output logic               pc_from_epc,
  output logic               vec_ovf,
  output logic               irq_clr,
  output logic               ie_set,
  output logic               ie_clr
);
  tc_state_e st_q, st_d;
  tc_cause_e kind_q, kind_d;
  logic      go;

  // next state: exceptions first, then return, then masked interrupt
  always_comb begin
    st_d   = st_q;
    kind_d = kind_q;
    go     = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (undef_hit) begin
          go = 1'b1; kind_d = CS_UNDEF; st_d = ST_SAVE;
        end else if (ovf_hit) begin
          go = 1'b1; kind_d = CS_OVF;   st_d = ST_SAVE;
        end else if (rfe_hit) begin
          st_d = ST_RET;
        end else if (insn_end && pend && ie) begin
          go = 1'b1; kind_d = CS_EXT;   st_d = ST_SAVE;
        end
      end
      ST_SAVE: st_d = ST_JUMP;
      ST_JUMP: st_d = ST_IDLE;
      ST_RET:  st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_IDLE;
    else         st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)  kind_q <= CS_EXT;
    else if (go)  kind_q <= kind_d;
  end

  // Moore strobes from the held state and cause
  always_comb begin
    epc_we      = (st_q == ST_SAVE);
    cause_we    = (st_q == ST_SAVE);
    cause_sel   = kind_q;
    pc_we       = (st_q == ST_JUMP) || (st_q == ST_RET);
    pc_from_epc = (st_q == ST_RET);
    vec_ovf     = (kind_q == CS_OVF);
    irq_clr     = (st_q == ST_JUMP) && (kind_q == CS_EXT);
    ie_clr      = (st_q == ST_JUMP);
    ie_set      = (st_q == ST_RET);
  end

  assign state   = st_q;
  assign trap_go = go;
endmodule

// File: rtl/trap_state_regs.sv
module trap_state_regs #(
  parameter int DATA_W  = 32,
  parameter int CAUSE_W = 2
) (
  input  logic               clk,
  input  logic               rst_ni,
  input  logic               epc_we,
  input  logic [DATA_W-1:0]  pc_cur,
  input  logic               cause_we,
  input  logic [CAUSE_W-1:0] cause_sel,
  input  logic               ie_set,
  input  logic               ie_clr,
  output logic [DATA_W-1:0]  epc_q,
  output logic [CAUSE_W-1:0] cause_q,
  output logic               ie_q
);
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)      epc_q <= '0;
    else if (epc_we)  epc_q <= pc_cur;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)       cause_q <= '0;
    else if (cause_we) cause_q <= cause_sel;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)      ie_q <= 1'b0;
    else if (ie_clr)  ie_q <= 1'b0;
    else if (ie_set)  ie_q <= 1'b1;
  end
endmodule

// File: rtl/trap_ctrl.sv
module trap_ctrl
  import trap_ctrl_pkg::*;
#(
  parameter int                DATA_W     = 32,
  parameter logic [DATA_W-1:0] VEC_BASE   = 32'hC000_0000,
  parameter logic [DATA_W-1:0] OVF_OFFSET = 32'h0000_0020,
  parameter int                SYNC_STG   = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               irq_req,
  input  logic               insn_end,
  input  logic               undef_hit,
  input  logic               ovf_hit,
  input  logic               rfe_hit,
  input  logic [DATA_W-1:0]  pc_cur,
  output logic               trap_go,
  output logic [1:0]         ctl_state,
  output logic               epc_we,
  output logic               cause_we,
  output logic [CAUSE_W-1:0] cause_sel,
  output logic               pc_we,
  output logic [DATA_W-1:0]  pc_next,
  output logic               irq_clr,
  output logic               irq_pend,
  output logic               int_en,
  output logic [DATA_W-1:0]  epc_q,
  output logic [CAUSE_W-1:0] cause_q
);
  localparam logic [DATA_W-1:0] VEC_OVF = VEC_BASE + OVF_OFFSET;

  logic      rst_ni;
  tc_state_e st;
  logic      pc_from_epc, vec_ovf, ie_set, ie_clr;

  trap_rst_sync #(.STAGES(SYNC_STG)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_ni(rst_ni)
  );

  trap_req_latch u_latch (
    .clk(clk), .rst_ni(rst_ni), .req_set(irq_req),
    .req_clr(irq_clr), .pend(irq_pend)
  );

  trap_seq_fsm u_fsm (
    .clk(clk), .rst_ni(rst_ni), .insn_end(insn_end),
    .undef_hit(undef_hit), .ovf_hit(ovf_hit), .rfe_hit(rfe_hit),
    .pend(irq_pend), .ie(int_en), .state(st), .trap_go(trap_go),
    .epc_we(epc_we), .cause_we(cause_we), .cause_sel(cause_sel),
    .pc_we(pc_we), .pc_from_epc(pc_from_epc), .vec_ovf(vec_ovf),
    .irq_clr(irq_clr), .ie_set(ie_set), .ie_clr(ie_clr)
  );

  trap_state_regs #(.DATA_W(DATA_W), .CAUSE_W(CAUSE_W)) u_regs (
    .clk(clk), .rst_ni(rst_ni), .epc_we(epc_we), .pc_cur(pc_cur),
    .cause_we(cause_we), .cause_sel(cause_sel), .ie_set(ie_set),
    .ie_clr(ie_clr), .epc_q(epc_q), .cause_q(cause_q), .ie_q(int_en)
  );

  // PC source: return address, overflow vector or common vector
  always_comb begin
    if (!pc_we)           pc_next = '0;
    else if (pc_from_epc) pc_next = epc_q;
    else if (vec_ovf)     pc_next = VEC_OVF;
    else                  pc_next = VEC_BASE;
  end

  assign ctl_state = st;
endmodule

// File: rtl/trap_ctrl_chk.sv
module trap_ctrl_chk #(
  parameter int DATA_W  = 32,
  parameter int CAUSE_W = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic               irq_req,
  input logic               insn_end,
  input logic               undef_hit,
  input logic               ovf_hit,
  input logic               rfe_hit,
  input logic [DATA_W-1:0]  pc_cur,
  input logic               trap_go,
  input logic [1:0]         ctl_state,
  input logic               epc_we,
  input logic               pc_we,
  input logic               irq_clr,
  input logic               irq_pend,
  input logic               int_en,
  input logic [DATA_W-1:0]  epc_q
);
  a_r2_pend_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_pend && !irq_clr) |=> irq_pend);

  a_r3_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_state == 2'd0 && !int_en && !undef_hit && !ovf_hit) |-> !trap_go);

  a_r4_boundary_only: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_state == 2'd0 && !insn_end && !undef_hit && !ovf_hit) |-> !trap_go);

  a_r5_save_follows: assert property (@(posedge clk) disable iff (!rst_n)
    trap_go |=> (ctl_state == 2'd1 && epc_we));

  a_r5_epc_capture: assert property (@(posedge clk) disable iff (!rst_n)
    epc_we |=> (epc_q == $past(pc_cur)));

  a_r6_mask_on_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_state == 2'd2) |=> !int_en);

  a_r6_save_then_jump: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_state == 2'd1) |=> (ctl_state == 2'd2 && pc_we));

  a_r7_clear_in_jump: assert property (@(posedge clk) disable iff (!rst_n)
    irq_clr |-> (ctl_state == 2'd2));

  a_r8_undef_taken: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_state == 2'd0 && undef_hit) |-> trap_go);

  a_r9_ret_unmasks: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_state == 2'd3) |=> int_en);

  a_r10_busy_no_go: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_state != 2'd0) |-> !trap_go);

  a_r1_strobes_apart: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({pc_we, epc_we}));
endmodule

bind trap_ctrl trap_ctrl_chk #(.DATA_W(DATA_W), .CAUSE_W(trap_ctrl_pkg::CAUSE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .insn_end(insn_end),
  .undef_hit(undef_hit), .ovf_hit(ovf_hit), .rfe_hit(rfe_hit),
  .pc_cur(pc_cur), .trap_go(trap_go), .ctl_state(ctl_state),
  .epc_we(epc_we), .pc_we(pc_we), .irq_clr(irq_clr),
  .irq_pend(irq_pend), .int_en(int_en), .epc_q(epc_q)
);

// File: tb/sim_trap_ctrl.sv
`timescale 1ns/1ps
module sim_trap_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        irq_req = 1'b0, insn_end = 1'b0, undef_hit = 1'b0;
  logic        ovf_hit = 1'b0, rfe_hit = 1'b0;
  logic [31:0] pc_cur = '0;
  logic        trap_go, epc_we, cause_we, pc_we, irq_clr, irq_pend, int_en;
  logic [1:0]  ctl_state, cause_sel, cause_q;
  logic [31:0] pc_next, epc_q;

  always #4 clk = ~clk;

  trap_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .insn_end(insn_end),
    .undef_hit(undef_hit), .ovf_hit(ovf_hit), .rfe_hit(rfe_hit),
    .pc_cur(pc_cur), .trap_go(trap_go), .ctl_state(ctl_state),
    .epc_we(epc_we), .cause_we(cause_we), .cause_sel(cause_sel),
    .pc_we(pc_we), .pc_next(pc_next), .irq_clr(irq_clr),
    .irq_pend(irq_pend), .int_en(int_en), .epc_q(epc_q), .cause_q(cause_q)
  );

  int    n_cmp = 0, n_bad = 0;
  bit    done = 1'b0;
  string cur_req = "R1";

  // behavioural reference: step 0 idle, 1 save, 2 jump, 3 return
  int          ms = 0, mk = 0;
  bit          mp = 0, mie = 0, mrs1 = 0, mrs2 = 0;
  logic [31:0] mepc = '0;
  int          mcause = 0;

  function automatic logic [31:0] vec_of(int k);
    return (k == 2) ? 32'hC000_0020 : 32'hC000_0000;
  endfunction

  task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", cur_req, what, act, exp, $time);
    end
  endtask

  task automatic compare();
    bit go_e;
    go_e = (ms == 0) && (undef_hit || ovf_hit ||
           (!rfe_hit && insn_end && mp && mie));
    chk("ctl_state", ctl_state, ms);
    chk("trap_go", trap_go, go_e);
    chk("epc_we", epc_we, ms == 1);
    chk("cause_we", cause_we, ms == 1);
    if (ms == 1) chk("cause_sel", cause_sel, mk);
    chk("pc_we", pc_we, ms == 2 || ms == 3);
    if (ms == 2) chk("pc_next vector", pc_next, vec_of(mk));
    if (ms == 3) chk("pc_next return", pc_next, mepc);
    chk("irq_clr", irq_clr, ms == 2 && mk == 0);
    chk("irq_pend", irq_pend, mp);
    chk("int_en", int_en, mie);
    chk("epc_q", epc_q, mepc);
    chk("cause_q", cause_q, mcause);
  endtask

  task automatic model_step();
    int ns, nk; bit np, nie; logic [31:0] nepc; int ncause;
    ns = ms; nk = mk; nie = mie; nepc = mepc; ncause = mcause;
    np = irq_req | (mp & !(ms == 2 && mk == 0));
    if (ms == 1) begin nepc = pc_cur; ncause = mk; end
    if (ms == 2) nie = 0;
    if (ms == 3) nie = 1;
    case (ms)
      0: begin
        if (undef_hit)      begin ns = 1; nk = 1; end
        else if (ovf_hit)   begin ns = 1; nk = 2; end
        else if (rfe_hit)   ns = 3;
        else if (insn_end && mp && mie) begin ns = 1; nk = 0; end
      end
      1: ns = 2;
      default: ns = 0;
    endcase
    if (!mrs2) begin
      ns = 0; nk = 0; np = 0; nie = 0; nepc = '0; ncause = 0;
    end
    ms = ns; mk = nk; mp = np; mie = nie; mepc = nepc; mcause = ncause;
    mrs2 = mrs1; mrs1 = rst_n;
  endtask

  task automatic cyc(bit req, bit iend, bit und, bit ovf, bit rfe, logic [31:0] pc);
    @(negedge clk);
    irq_req = req; insn_end = iend; undef_hit = und; ovf_hit = ovf;
    rfe_hit = rfe; pc_cur = pc;
    #1 compare();
    @(posedge clk);
    model_step();
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0, 32'h0040_0100 + i * 4);
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(8 * 100000);
    n_bad++;
    $display("FAIL watchdog expired in %s", cur_req);
    summary();
  end

  initial begin
    // R1: reset state, held and then released
    cur_req = "R1";
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); #1 compare(); @(posedge clk); model_step();
    end
    rst_n = 1'b1;
    idle(4);

    // R2 and R3: request latched, masked while the enable is clear
    cur_req = "R2";
    cyc(1, 0, 0, 0, 0, 32'h0040_0004);
    idle(3);
    cur_req = "R3";
    cyc(0, 1, 0, 0, 0, 32'h0040_0008);
    cyc(0, 1, 0, 0, 0, 32'h0040_000C);
    idle(2);

    // R9: return with EPC 0 sets the enable
    cur_req = "R9";
    cyc(0, 0, 0, 0, 1, 32'h0040_0010);
    idle(2);

    // R4: enabled and pending, but no instruction end yet
    cur_req = "R4";
    idle(3);
    // R5, R6, R7: external trap taken at instruction end
    cur_req = "R5";
    cyc(0, 1, 0, 0, 0, 32'h0040_0020);
    cyc(0, 0, 0, 0, 0, 32'h0040_0024);
    // R10: exception and return inputs during the jump step are ignored
    cur_req = "R10";
    cyc(0, 1, 1, 1, 1, 32'h0040_0028);
    cur_req = "R6";
    idle(2);

    // R9: return to the saved address
    cur_req = "R9";
    cyc(0, 0, 0, 0, 1, 32'h0040_0030);
    idle(2);

    // R7: new request in the clear cycle survives
    cur_req = "R7";
    cyc(1, 0, 0, 0, 0, 32'h0040_0040);
    cyc(0, 1, 0, 0, 0, 32'h0040_0044);
    cyc(0, 0, 0, 0, 0, 32'h0040_0048);
    cyc(1, 0, 0, 0, 0, 32'h0040_004C);
    idle(2);

    // R8: undefined instruction with interrupts masked
    cur_req = "R8";
    cyc(0, 0, 1, 0, 0, 32'h0040_0050);
    idle(3);
    // R8: overflow vector and cause 2
    cyc(0, 0, 0, 1, 0, 32'h0040_0060);
    idle(3);
    // R8: undefined and overflow together, undefined wins
    cyc(0, 1, 1, 1, 1, 32'h0040_0070);
    idle(3);
    // R8: enable, then overflow beats an eligible interrupt that stays pending
    cyc(0, 0, 0, 0, 1, 32'h0040_0080);
    idle(2);
    cyc(1, 0, 0, 0, 0, 32'h0040_0084);
    cyc(0, 1, 0, 1, 1, 32'h0040_0088);
    idle(3);
    cyc(0, 0, 0, 0, 1, 32'h0040_0090);
    idle(2);
    cyc(0, 1, 0, 0, 0, 32'h0040_0094);
    idle(3);

    // R10: mixed random traffic compared every cycle
    cur_req = "R10";
    for (int i = 0; i < 600; i++)
      cyc(($urandom % 7) == 0, ($urandom % 3) == 0, ($urandom % 23) == 0,
          ($urandom % 19) == 0, ($urandom % 11) == 0, $urandom);
    idle(4);
    summary();
  end
endmodule